// File: doc/BRIEF.md
# Escalating Multi-Stage Watchdog

The block supervises software by counting prescaled ticks and escalating when nobody services it. The counter runs through up to four stages in order. Each stage has its own timeout and its own expiry action: nothing, an interrupt, or a system reset pulse whose width is programmable. Stages whose action is "nothing" are passed over. After the last live stage the watchdog goes idle. A write to the feed register starts the walk again from the first live stage.

All configuration goes through a write-only register port. A key register guards it. Until the key register holds the unlock constant, writes to every other register are dropped. Software unlocks the port, changes what it needs and locks it again by writing any other value, normally zero.

The interrupt can be latched (level) or one cycle wide (edge). An enable register gates both kinds, and a clear register drops the latched status. The asynchronous active-low reset input is released through a two-flop synchronizer inside the block.

Top module: `esc_wdog`

## Requirements
- R1: A write to any address other than the key register (address 0) changes nothing unless the key register holds 32'h50D83AA1. The key register is always writable, and writing any other value to it locks the port again.
- R2: The prescale register (address 2) gives a tick every N clocks, with N = 0 treated as 1. A stage with timeout T (0 treated as 1) expires on the N*T-th clock after it starts. When the watchdog starts from a write, its first action appears on the outputs N*T+1 cycles after the clock edge that takes the write.
- R3: An unlocked write of any data to the feed register (address 3) restarts the watchdog from its first live stage. The restart takes effect on the edge after the write edge, with all counts cleared.
- R4: The control register (address 1) holds a 2-bit action per stage at bits [7:6], [9:8], [11:10] and [13:12] for stages 0 to 3. The codes are 0 = off, 1 = interrupt, 2 = system reset and 3 = off. Stage timeouts are at addresses 8 to 11.
- R5: Off stages are skipped without spending any time. After the last live stage expires, the watchdog stays idle and produces no further action until it is fed or re-enabled.
- R6: When a live stage expires, its action is taken and the next live stage starts counting from zero on the same edge.
- R7: Control bit 0 enables the watchdog. Clearing it stops counting. A write that sets it while it is clear restarts from the first live stage.
- R8: A reset action drives sys_rst_o high for (L+1)*RST_STEP cycles, where L is control bits [5:3]. The pulse starts in the cycle after the expiry edge. sys_rst_o is low after reset.
- R9: When control bit 1 is set, an interrupt action sets a latched status that holds irq_o high. The status stays set until an unlocked write of data bit 0 = 1 to the clear register (address 5). irq_o is low after reset.
- R10: When control bit 2 is set, an interrupt action produces a single-cycle pulse on irq_o.
- R11: The interrupt enable register (address 4, bit 0) gates both interrupt kinds. A status latched while it was clear shows on irq_o as soon as it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| irq_o | output | 1 | Watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A sweep over prescale values 0 to 3 and timeouts 1 to 3 pins down the expiry cycle exactly. It separates a correct divide from an off-by-one in either the tick counter or the stage counter. A second sweep of all eight reset-length codes tells a correct pulse width from one that is a cycle short or long. Mixed stage patterns check the ordering rules. Interrupt-then-reset separates escalation from a restart. Leading off stages with large timeouts show whether skipping costs time. A feed during the second stage shows whether the sequence returns to the first stage or only restarts the current one. Writes made while locked (config, feed, clear) are followed by the output they would have changed, so a leaky key check becomes visible at the pins.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

  localparam logic [31:0] WD_KEY = 32'h50D83AA1;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_RST  = 2'd2,
    ACT_NONE = 2'd3
  } act_e;

  localparam logic [3:0] A_KEY    = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_PRESC  = 4'd2;
  localparam logic [3:0] A_FEED   = 4'd3;
  localparam logic [3:0] A_INTEN  = 4'd4;
  localparam logic [3:0] A_INTCLR = 4'd5;
  localparam logic [3:0] A_TMO    = 4'd8;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_LVL  = 1;
  localparam int CTRL_EDGE = 2;
  localparam int CTRL_RLEN = 3;
  localparam int CTRL_ACT0 = 6;

endpackage

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
  import esc_wdog_pkg::*;
#(
  parameter int PW   = 16,
  parameter int TW   = 16,
  parameter int NSTG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_addr,
  input  logic [31:0]              wr_data,
  output logic                     unlocked,
  output logic                     en,
  output logic                     lvl_en,
  output logic                     edge_en,
  output logic [2:0]               rst_len,
  output logic [NSTG-1:0][1:0]     acts,
  output logic [PW-1:0]            presc,
  output logic [NSTG-1:0][TW-1:0]  tmo,
  output logic                     int_ena,
  output logic                     int_clr,
  output logic                     restart
);

  localparam int CW = CTRL_ACT0 + 2 * NSTG;

  logic [31:0]             key_q, key_d;
  logic [CW-1:0]           ctrl_q, ctrl_d;
  logic [PW-1:0]           presc_q, presc_d;
  logic [NSTG-1:0][TW-1:0] tmo_q, tmo_d;
  logic                    inten_q, inten_d;
  logic                    restart_q, restart_d;
  logic                    wr_ok;

  always_comb begin
    wr_ok   = wr_en && (key_q == WD_KEY);
    key_d   = key_q;
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    tmo_d   = tmo_q;
    inten_d = inten_q;
    if (wr_en && (wr_addr == A_KEY)) key_d = wr_data;
    if (wr_ok) begin
      case (wr_addr)
        A_CTRL:  ctrl_d  = wr_data[CW-1:0];
        A_PRESC: presc_d = wr_data[PW-1:0];
        A_INTEN: inten_d = wr_data[0];
        default: ;
      endcase
      for (int s = 0; s < NSTG; s++) begin
        if (wr_addr == (A_TMO + 4'(s))) tmo_d[s] = wr_data[TW-1:0];
      end
    end
    restart_d = wr_ok && ((wr_addr == A_FEED) ||
                ((wr_addr == A_CTRL) && wr_data[CTRL_EN] && !ctrl_q[CTRL_EN]));
    int_clr   = wr_ok && (wr_addr == A_INTCLR) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= '0;
      ctrl_q    <= '0;
      presc_q   <= '0;
      tmo_q     <= '0;
      inten_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      key_q     <= key_d;
      ctrl_q    <= ctrl_d;
      presc_q   <= presc_d;
      tmo_q     <= tmo_d;
      inten_q   <= inten_d;
      restart_q <= restart_d;
    end
  end

  always_comb begin
    for (int s = 0; s < NSTG; s++) acts[s] = ctrl_q[CTRL_ACT0 + 2*s +: 2];
  end

  assign unlocked = (key_q == WD_KEY);
  assign en       = ctrl_q[CTRL_EN];
  assign lvl_en   = ctrl_q[CTRL_LVL];
  assign edge_en  = ctrl_q[CTRL_EDGE];
  assign rst_len  = ctrl_q[CTRL_RLEN +: 3];
  assign presc    = presc_q;
  assign tmo      = tmo_q;
  assign int_ena  = inten_q;
  assign restart  = restart_q;

endmodule

// File: rtl/esc_wdog_seq.sv
module esc_wdog_seq
  import esc_wdog_pkg::*;
#(
  parameter int PW   = 16,
  parameter int TW   = 16,
  parameter int NSTG = 4,
  parameter int SW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [NSTG-1:0][1:0]     acts,
  input  logic [PW-1:0]            presc,
  input  logic [NSTG-1:0][TW-1:0]  tmo,
  input  logic                     restart,
  output logic                     run,
  output logic                     expire,
  output act_e                     exp_act
);

  logic [PW-1:0] pcnt_q, pcnt_d, pdiv;
  logic [TW-1:0] scnt_q, scnt_d, tlim;
  logic [SW-1:0] stg_q, stg_d, first_idx, nxt_idx;
  logic          run_q, run_d, tick, first_ok, nxt_ok;

  function automatic logic is_live(input logic [1:0] a);
    return (a == ACT_IRQ) || (a == ACT_RST);
  endfunction

  always_comb begin
    pdiv    = (presc == '0) ? PW'(1) : presc;
    tlim    = (tmo[stg_q] == '0) ? TW'(1) : tmo[stg_q];
    tick    = run_q && (pcnt_q == pdiv - PW'(1));
    expire  = tick && (scnt_q == tlim - TW'(1));
    exp_act = act_e'(acts[stg_q]);

    first_ok  = 1'b0;
    first_idx = '0;
    nxt_ok    = 1'b0;
    nxt_idx   = '0;
    for (int j = NSTG - 1; j >= 0; j--) begin
      if (is_live(acts[j])) begin
        first_ok  = 1'b1;
        first_idx = SW'(j);
        if (j > int'(stg_q)) begin
          nxt_ok  = 1'b1;
          nxt_idx = SW'(j);
        end
      end
    end

    run_d  = run_q;
    stg_d  = stg_q;
    pcnt_d = pcnt_q;
    scnt_d = scnt_q;
    if (!en) begin
      run_d  = 1'b0;
      pcnt_d = '0;
      scnt_d = '0;
    end else if (restart) begin
      run_d  = first_ok;
      stg_d  = first_idx;
      pcnt_d = '0;
      scnt_d = '0;
    end else if (run_q) begin
      if (tick) begin
        pcnt_d = '0;
        if (expire) begin
          scnt_d = '0;
          if (nxt_ok) stg_d = nxt_idx;
          else        run_d = 1'b0;
        end else begin
          scnt_d = scnt_q + TW'(1);
        end
      end else begin
        pcnt_d = pcnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stg_q  <= '0;
      pcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      run_q  <= run_d;
      stg_q  <= stg_d;
      pcnt_q <= pcnt_d;
      scnt_q <= scnt_d;
    end
  end

  assign run = run_q;

endmodule

// File: rtl/esc_wdog_out.sv
module esc_wdog_out
  import esc_wdog_pkg::*;
#(
  parameter int RST_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  act_e       exp_act,
  input  logic [2:0] rst_len,
  input  logic       lvl_en,
  input  logic       edge_en,
  input  logic       int_ena,
  input  logic       int_clr,
  output logic       int_raw,
  output logic       edge_pulse,
  output logic       irq_o,
  output logic       sys_rst_o
);

  localparam int LW = $clog2(8 * RST_STEP + 1);

  logic [LW-1:0] rcnt_q, rcnt_d;
  logic          raw_q, raw_d, edge_q, edge_d;
  logic          rst_fire, irq_fire;

  always_comb begin
    rst_fire = expire && (exp_act == ACT_RST);
    irq_fire = expire && (exp_act == ACT_IRQ);
    if (rst_fire)            rcnt_d = LW'((int'(rst_len) + 1) * RST_STEP);
    else if (rcnt_q != '0)   rcnt_d = rcnt_q - LW'(1);
    else                     rcnt_d = rcnt_q;
    if (irq_fire)            raw_d = 1'b1;
    else if (int_clr)        raw_d = 1'b0;
    else                     raw_d = raw_q;
    edge_d = irq_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      raw_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      raw_q  <= raw_d;
      edge_q <= edge_d;
    end
  end

  assign int_raw    = raw_q;
  assign edge_pulse = edge_q;
  assign sys_rst_o  = (rcnt_q != '0);
  assign irq_o      = int_ena && ((lvl_en && raw_q) || (edge_en && edge_q));

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
#(
  parameter int PRESC_W    = 16,
  parameter int TMO_W      = 16,
  parameter int NUM_STAGES = 4,
  parameter int RST_STEP   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        irq_o,
  output logic        sys_rst_o
);

  localparam int SW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

  logic [1:0]                          rs_q;
  logic                                arst_n;
  logic                                unlocked, ctl_en, lvl_en, edge_en;
  logic [2:0]                          rst_len;
  logic [NUM_STAGES-1:0][1:0]          acts;
  logic [PRESC_W-1:0]                  presc;
  logic [NUM_STAGES-1:0][TMO_W-1:0]    tmo;
  logic                                int_ena, int_clr, restart;
  logic                                seq_run, expire, int_raw, edge_pulse;
  act_e                                exp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  esc_wdog_regs #(.PW(PRESC_W), .TW(TMO_W), .NSTG(NUM_STAGES)) u_regs (
    .clk(clk), .rst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlocked(unlocked), .en(ctl_en), .lvl_en(lvl_en),
    .edge_en(edge_en), .rst_len(rst_len), .acts(acts), .presc(presc),
    .tmo(tmo), .int_ena(int_ena), .int_clr(int_clr), .restart(restart)
  );

  esc_wdog_seq #(.PW(PRESC_W), .TW(TMO_W), .NSTG(NUM_STAGES), .SW(SW)) u_seq (
    .clk(clk), .rst_n(arst_n), .en(ctl_en), .acts(acts), .presc(presc),
    .tmo(tmo), .restart(restart), .run(seq_run), .expire(expire),
    .exp_act(exp_act)
  );

  esc_wdog_out #(.RST_STEP(RST_STEP)) u_out (
    .clk(clk), .rst_n(arst_n), .expire(expire), .exp_act(exp_act),
    .rst_len(rst_len), .lvl_en(lvl_en), .edge_en(edge_en),
    .int_ena(int_ena), .int_clr(int_clr), .int_raw(int_raw),
    .edge_pulse(edge_pulse), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

endmodule

// File: rtl/esc_wdog_chk.sv
module esc_wdog_chk
  import esc_wdog_pkg::*;
#(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic          unlocked,
  input logic          en,
  input logic          run,
  input logic          restart,
  input logic          expire,
  input act_e          exp_act,
  input logic          int_raw,
  input logic          int_clr,
  input logic          edge_pulse,
  input logic          sys_rst_o,
  input logic [PW-1:0] presc
);

  // R1
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_PRESC) && !unlocked) |=> $stable(presc));

  // R7
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> !run);

  // R8
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(expire && (exp_act == ACT_RST)));

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_raw && !int_clr) |=> int_raw);

  // R10
  edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> !edge_pulse);

endmodule

bind esc_wdog esc_wdog_chk #(.PW(PRESC_W)) u_chk (
  .clk(clk), .rst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .unlocked(unlocked), .en(ctl_en), .run(seq_run), .restart(restart),
  .expire(expire), .exp_act(exp_act), .int_raw(int_raw),
  .int_clr(int_clr), .edge_pulse(edge_pulse), .sys_rst_o(sys_rst_o),
  .presc(presc)
);

// File: tb/test_esc_wdog.sv
module test_esc_wdog;

  localparam logic [3:0] KEY = 4'd0, CTRL = 4'd1, PRE = 4'd2, FEED = 4'd3;
  localparam logic [3:0] IEN = 4'd4, ICLR = 4'd5, TM0 = 4'd8;
  localparam logic [31:0] UNLOCK = 32'h50D83AA1;
  localparam int STEP = 2;

  logic clk, rst_n, wr_en, irq_o, sys_rst_o;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  int nchk = 0, nfail = 0;
  bit done = 0;

  esc_wdog i_esc_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] cw(input int e, input int l, input int g,
      input int rl, input int a0, input int a1, input int a2, input int a3);
    return 32'(e) | (32'(l) << 1) | (32'(g) << 2) | (32'(rl) << 3) |
           (32'(a0) << 6) | (32'(a1) << 8) | (32'(a2) << 10) | (32'(a3) << 12);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // configure with enable clear, clear status, then enable (restart reference)
  task automatic arm(input logic [31:0] cfg, input int p, input int t0,
                     input int t1, input int t2, input int t3);
    wr(CTRL, cfg);
    wr(PRE, 32'(p));
    wr(TM0, 32'(t0));
    wr(TM0 + 4'd1, 32'(t1));
    wr(TM0 + 4'd2, 32'(t2));
    wr(TM0 + 4'd3, 32'(t3));
    wr(ICLR, 32'd1);
    wr(CTRL, cfg | 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R8 reset", sys_rst_o, 1'b0);
    chk("R9 reset", irq_o, 1'b0);

    // R1: writes while locked are dropped
    wr(IEN, 32'd1);
    wr(PRE, 32'd1);
    wr(TM0, 32'd1);
    wr(CTRL, cw(1, 0, 0, 0, 2, 0, 0, 0));
    wait_cyc(30);
    chk("R1 locked cfg", sys_rst_o, 1'b0);

    wr(KEY, UNLOCK);
    wr(IEN, 32'd1);

    // R2: prescale x timeout sweep
    for (int n = 0; n < 4; n++) begin
      for (int t = 1; t < 4; t++) begin
        int ne;
        ne = (n == 0) ? 1 : n;
        arm(cw(0, 1, 0, 0, 1, 0, 0, 0), n, t, 1, 1, 1);
        wait_cyc(ne * t);
        chk("R2 before", irq_o, 1'b0);
        wait_cyc(1);
        chk("R2 expiry", irq_o, 1'b1);
      end
    end
    wait_cyc(10);
    chk("R9 level holds", irq_o, 1'b1);

    // R1: relock, then feed and clear are ignored
    arm(cw(0, 1, 0, 0, 1, 0, 0, 0), 2, 10, 1, 1, 1);
    wr(KEY, 32'd0);
    wr(FEED, 32'h0000_0001);
    wait_cyc(16);
    chk("R1 locked feed", irq_o, 1'b0);
    wait_cyc(1);
    chk("R1 locked feed", irq_o, 1'b1);
    wr(ICLR, 32'd1);
    wait_cyc(2);
    chk("R1 locked clear", irq_o, 1'b1);
    wr(KEY, UNLOCK);
    wr(ICLR, 32'd1);
    chk("R9 clear", irq_o, 1'b0);

    // R11: enable gate
    wr(IEN, 32'd0);
    arm(cw(0, 1, 0, 0, 1, 0, 0, 0), 1, 2, 1, 1, 1);
    wait_cyc(10);
    chk("R11 gated", irq_o, 1'b0);
    wr(IEN, 32'd1);
    chk("R11 released", irq_o, 1'b1);

    // R10: edge pulse
    arm(cw(0, 0, 1, 0, 1, 0, 0, 0), 2, 3, 1, 1, 1);
    wait_cyc(6);
    chk("R10 before", irq_o, 1'b0);
    wait_cyc(1);
    chk("R10 pulse", irq_o, 1'b1);
    wait_cyc(1);
    chk("R10 single", irq_o, 1'b0);

    // R6 / R4: interrupt then reset escalation
    arm(cw(0, 1, 0, 2, 1, 2, 0, 0), 3, 2, 2, 1, 1);
    wait_cyc(6);
    chk("R6 stage0 early", irq_o, 1'b0);
    wait_cyc(1);
    chk("R4 irq code", irq_o, 1'b1);
    chk("R6 no reset yet", sys_rst_o, 1'b0);
    wait_cyc(5);
    chk("R6 stage1 early", sys_rst_o, 1'b0);
    wait_cyc(1);
    chk("R4 reset code", sys_rst_o, 1'b1);
    wait_cyc(5);
    chk("R8 pulse end", sys_rst_o, 1'b1);
    wait_cyc(1);
    chk("R8 pulse off", sys_rst_o, 1'b0);
    wait_cyc(50);
    chk("R5 idle", sys_rst_o, 1'b0);

    // R8: all reset length codes
    for (int rl = 0; rl < 8; rl++) begin
      int len;
      len = (rl + 1) * STEP;
      arm(cw(0, 0, 0, rl, 2, 0, 0, 0), 1, 1, 1, 1, 1);
      wait_cyc(1);
      chk("R8 pre", sys_rst_o, 1'b0);
      wait_cyc(1);
      chk("R8 start", sys_rst_o, 1'b1);
      wait_cyc(len - 1);
      chk("R8 last", sys_rst_o, 1'b1);
      wait_cyc(1);
      chk("R8 end", sys_rst_o, 1'b0);
    end

    // R5: leading off stages (codes 0 and 3) skipped
    arm(cw(0, 1, 0, 0, 0, 3, 2, 0), 2, 5, 5, 3, 1);
    wait_cyc(6);
    chk("R5 skip early", sys_rst_o, 1'b0);
    wait_cyc(1);
    chk("R5 skip fire", sys_rst_o, 1'b1);
    wait_cyc(60);
    chk("R5 idle after last", sys_rst_o, 1'b0);
    chk("R5 no irq", irq_o, 1'b0);

    // R3: periodic feed keeps it quiet, then times from last feed
    arm(cw(0, 1, 0, 0, 1, 0, 0, 0), 2, 10, 1, 1, 1);
    for (int k = 0; k < 4; k++) begin
      wait_cyc(10);
      wr(FEED, 32'hDEAD_0000 + 32'(k));
    end
    chk("R3 fed", irq_o, 1'b0);
    wait_cyc(20);
    chk("R3 before", irq_o, 1'b0);
    wait_cyc(1);
    chk("R3 after feed", irq_o, 1'b1);

    // R3: feed in stage 1 returns to stage 0
    arm(cw(0, 1, 0, 0, 1, 2, 0, 0), 1, 4, 8, 1, 1);
    wait_cyc(5);
    chk("R3 stage0", irq_o, 1'b1);
    wr(FEED, 32'h0);
    wait_cyc(7);
    chk("R3 no reset", sys_rst_o, 1'b0);
    wait_cyc(5);
    chk("R3 restage", sys_rst_o, 1'b0);
    wait_cyc(1);
    chk("R3 restage fire", sys_rst_o, 1'b1);

    // R7: disable stops, re-enable restarts
    arm(cw(0, 1, 0, 0, 1, 0, 0, 0), 1, 5, 1, 1, 1);
    wr(CTRL, cw(0, 1, 0, 0, 1, 0, 0, 0));
    wait_cyc(30);
    chk("R7 stopped", irq_o, 1'b0);
    wr(CTRL, cw(1, 1, 0, 0, 1, 0, 0, 0));
    wait_cyc(5);
    chk("R7 restart early", irq_o, 1'b0);
    wait_cyc(1);
    chk("R7 restart fire", irq_o, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule